// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

The block is a chain of four-bit binary counter stages that all run from one shared clock. On each rising clock edge the chain steps up by one or down by one, as the direction input selects. It moves only while the active-low carry-in is asserted. A parallel preset value is loaded as soon as the preset-enable input rises, without waiting for a clock edge. A high on the reset input clears every stage at once.

Each stage passes an active-low carry to the next stage. That carry is asserted only while the stage's own carry-in is asserted and the stage holds its terminal value: all ones when counting up, all zeros when counting down. As a result, the stages together behave as one wide counter. The final carry-out can feed a further cascade outside the block.

Each stage decodes its inputs into one of five modes. In priority order these are clear, load, hold, count-up and count-down. The count register is the state. Its transitions are:
- clear to zero, asynchronously;
- load of the preset, asynchronously on the rise of preset-enable and again on every clock edge while it stays high;
- hold on a clock edge while carry-in is inactive;
- increment or decrement on a clock edge while carry-in is active.

Top module: `updn_cascade`

## Requirements
- R1: With reset low, preset-enable low, carry-in low (active) and direction high, every rising clock edge adds one to the full chain value. All ones wraps to zero.
- R2: With the same conditions but direction low, every rising clock edge subtracts one. Zero wraps to all ones.
- R3: While carry-in is high (inactive), the count keeps its value across clock edges.
- R4: A rise of preset-enable loads the preset value into the count at once, with no clock edge. While preset-enable stays high, every clock edge reloads the preset and the count does not advance.
- R5: A high on reset clears the count to zero at once, with no clock edge. Reset takes priority over preset-enable and over counting.
- R6: Carry-out is low (active) exactly when carry-in is low and the count is at its terminal value for the current direction: all ones for up, all zeros for down. It follows a change of direction or carry-in without waiting for a clock.
- R7: After preset-enable falls, the first rising clock edge steps the count from the preset value.
- R8: Stage k (stage 0 holds the low four bits) steps on a clock edge only when every lower stage is at its terminal value with carry-in active. This makes the chain count as one binary number of 4·STAGES bits, for example 0x0F up to 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared count clock, rising edge active |
| rst | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Asynchronous preset enable, active high |
| dir | input | 1 | Count direction: 1 up, 0 down |
| cin_n | input | 1 | Carry-in to stage 0, active low, enables counting |
| preset | input | STAGES*W | Preset value, stage 0 in the low bits |
| count | output | STAGES*W | Current chain value, stage 0 in the low bits |
| cout_n | output | 1 | Carry-out of the last stage, active low |

## Verification
Three functions can land in the same clock cycle: the asynchronous preset, the asynchronous reset and the clocked count step. The bench provokes this by raising preset-enable a couple of nanoseconds after a clock edge. It then raises reset while the preset is still held, and releases each of them at different points inside the cycle. Each outcome is judged against the priority order, reset over preset over counting. The behavioural reference model applies the same async events at the moment they occur. The bench also samples the outputs in the middle of the cycle, so the count is seen to change before the next clock edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Stage operating modes, listed in decreasing priority.
    typedef enum logic [2:0] {
        MODE_CLEAR = 3'd0,
        MODE_LOAD  = 3'd1,
        MODE_HOLD  = 3'd2,
        MODE_UP    = 3'd3,
        MODE_DOWN  = 3'd4
    } cnt_mode_e;

endpackage

// File: rtl/updn_mode_dec.sv
module updn_mode_dec
    import updn_pkg::*;
(
    input  logic      rst,
    input  logic      load,
    input  logic      cin_n,
    input  logic      dir,
    output cnt_mode_e mode
);

    // Priority: clear, then load, then carry gating, then direction (R5, R4, R3).
    always_comb begin
        if (rst) begin
            mode = MODE_CLEAR;
        end else if (load) begin
            mode = MODE_LOAD;
        end else if (cin_n) begin
            mode = MODE_HOLD;
        end else if (dir) begin
            mode = MODE_UP;
        end else begin
            mode = MODE_DOWN;
        end
    end

endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dir,
    input  logic         cin_n,
    input  logic [W-1:0] preset,
    output logic [W-1:0] q,
    output logic         cout_n
);

    localparam logic [W-1:0] ONE   = W'(1);
    localparam logic [W-1:0] ALL_1 = {W{1'b1}};

    cnt_mode_e    mode;
    logic [W-1:0] q_next;
    logic         at_term;

    updn_mode_dec u_dec (
        .rst   (rst),
        .load  (load),
        .cin_n (cin_n),
        .dir   (dir),
        .mode  (mode)
    );

    // Next-state selection for a clock edge.
    always_comb begin
        unique case (mode)
            MODE_CLEAR: q_next = '0;
            MODE_LOAD:  q_next = preset;
            MODE_HOLD:  q_next = q;
            MODE_UP:    q_next = q + ONE;
            MODE_DOWN:  q_next = q - ONE;
            default:    q_next = q;
        endcase
    end

    // State register: clear and preset act without a clock (R5, R4).
    always_ff @(posedge clk or posedge rst or posedge load) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= preset;
        end else begin
            q <= q_next;
        end
    end

    // Output: combinational terminal-count carry (R6).
    always_comb begin
        at_term = dir ? (q == ALL_1) : (q == '0);
        cout_n  = ~(~cin_n & at_term);
    end

endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
    parameter int STAGES = 2,
    parameter int W      = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  dir,
    input  logic                  cin_n,
    input  logic [STAGES*W-1:0]   preset,
    output logic [STAGES*W-1:0]   count,
    output logic                  cout_n
);

    localparam int TOTAL = STAGES * W;

    logic [STAGES:0] carry_n;

    assign carry_n[0] = cin_n;

    // Ripple the active-low carry through parallel-clocked stages (R8).
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        updn_stage #(.W(W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .dir    (dir),
            .cin_n  (carry_n[g]),
            .preset (preset[g*W +: W]),
            .q      (count[g*W +: W]),
            .cout_n (carry_n[g+1])
        );
    end

    assign cout_n = carry_n[STAGES];

endmodule

// File: rtl/updn_cascade_chk.sv
module updn_cascade_chk #(
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic          dir,
    input logic          cin_n,
    input logic [TW-1:0] preset,
    input logic [TW-1:0] count,
    input logic          cout_n
);

    localparam logic [TW-1:0] ONE   = TW'(1);
    localparam logic [TW-1:0] ALL_1 = {TW{1'b1}};

    logic [TW-1:0] p_cnt;
    logic          p_dir;
    logic          p_cin;
    logic          clean;
    logic [TW-1:0] want;

    // Inputs and count as seen by the design at the clock edge.
    always_ff @(posedge clk) begin
        p_cnt <= count;
        p_dir <= dir;
        p_cin <= cin_n;
    end

    // Cleared by any asynchronous event, set again at a quiet falling edge.
    always_ff @(negedge clk or posedge rst or posedge load) begin
        if (rst || load) begin
            clean <= 1'b0;
        end else begin
            clean <= 1'b1;
        end
    end

    always_comb begin
        if (p_cin) begin
            want = p_cnt;
        end else if (p_dir) begin
            want = p_cnt + ONE;
        end else begin
            want = p_cnt - ONE;
        end
    end

    AST_STEP_ONE: assert property (@(negedge clk) disable iff (rst)
        (clean && !load) |-> (count == want)) else $error("step");        // R1
    AST_STEP_DOWN: assert property (@(negedge clk) disable iff (rst)
        (clean && !load && !p_cin && !p_dir) |-> (count == p_cnt - ONE)) else $error("down"); // R2
    AST_HOLD_IDLE: assert property (@(negedge clk) disable iff (rst)
        (clean && !load && p_cin) |-> (count == p_cnt)) else $error("hold"); // R3
    AST_LOAD_HELD: assert property (@(negedge clk) disable iff (rst)
        (load && $past(load) && $stable(preset)) |-> (count == preset)) else $error("load"); // R4
    AST_CLEAR_WINS: assert property (@(negedge clk)
        rst |-> (count == '0)) else $error("clear");                      // R5
    AST_CARRY_TERM: assert property (@(negedge clk) disable iff (rst)
        !cout_n |-> (!cin_n && (count == (dir ? ALL_1 : '0)))) else $error("carry"); // R6
    AST_CARRY_SEEN: assert property (@(negedge clk) disable iff (rst)
        (!cin_n && (count == (dir ? ALL_1 : '0))) |-> !cout_n) else $error("carry2"); // R6

endmodule

bind updn_cascade updn_cascade_chk #(.TW(STAGES*W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .dir    (dir),
    .cin_n  (cin_n),
    .preset (preset),
    .count  (count),
    .cout_n (cout_n)
);

// File: tb/updn_cascade_bench.sv
module updn_cascade_bench;

    localparam int ST   = 2;
    localparam int W    = 4;
    localparam int TW   = ST * W;
    localparam int MODV = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          load = 1'b0;
    logic          dir = 1'b1;
    logic          cin_n = 1'b0;
    logic [TW-1:0] preset = '0;
    logic [TW-1:0] count;
    logic          cout_n;

    int    ref_cnt = 0;
    int    n_chk   = 0;
    int    n_fail  = 0;
    bit    run_cmp = 1'b0;
    bit    done    = 1'b0;
    string phase   = "R5";

    always #4 clk = ~clk;

    updn_cascade #(.STAGES(ST), .W(W)) u_updn_cascade (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .dir    (dir),
        .cin_n  (cin_n),
        .preset (preset),
        .count  (count),
        .cout_n (cout_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_cout();
        if (!cin_n && (dir ? (ref_cnt == MODV - 1) : (ref_cnt == 0))) return 1'b0;
        return 1'b1;
    endfunction

    // Behavioural reference: one integer for the whole chain.
    always @(posedge clk) begin
        if (!rst) begin
            if (load) ref_cnt = int'(preset);
            else if (!cin_n) ref_cnt = dir ? (ref_cnt + 1) % MODV : (ref_cnt + MODV - 1) % MODV;
        end
    end
    always @(posedge rst) ref_cnt = 0;
    always @(posedge load) if (!rst) ref_cnt = int'(preset);

    always @(negedge clk) begin
        if (run_cmp) begin
            chk(phase, 32'(count), 32'(ref_cnt));
            chk(phase, 32'(cout_n), 32'(exp_cout()));
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #1 rst = 1'b1;
        run_cmp = 1'b1;
        phase = "R5 reset";
        wait_cycles(3);
        rst = 1'b0;

        phase = "R1 up+wrap";
        dir = 1'b1; cin_n = 1'b0;
        wait_cycles(300);

        phase = "R3 hold";
        cin_n = 1'b1;
        wait_cycles(10);

        phase = "R2 down+wrap";
        cin_n = 1'b0; dir = 1'b0;
        wait_cycles(300);

        // Mid-cycle preset then resume across stage boundary.
        preset = 8'h0F;
        @(posedge clk); #2;
        load = 1'b1;
        #1 chk("R4 async load", 32'(count), 32'h0F);
        phase = "R4 held";
        wait_cycles(3);
        dir = 1'b1;
        @(posedge clk); #2;
        load = 1'b0;
        phase = "R7 resume";
        @(posedge clk); #1;
        chk("R7 first step from preset", 32'(count), 32'h10);
        chk("R8 carry into upper stage", 32'(count[7:4]), 32'h1);
        wait_cycles(5);

        // Carry follows direction and carry-in without a clock.
        preset = 8'hFF;
        wait_cycles(1);
        @(posedge clk); #1;
        load = 1'b1;
        #1 chk("R6 up at ones", 32'(cout_n), 32'h0);
        dir = 1'b0;
        #1 chk("R6 down at ones", 32'(cout_n), 32'h1);
        dir = 1'b1; cin_n = 1'b1;
        #1 chk("R6 carry-in off", 32'(cout_n), 32'h1);
        cin_n = 1'b0;
        phase = "R4 held ones";
        wait_cycles(2);

        // Reset while preset is held: reset wins at once.
        @(posedge clk); #2;
        rst = 1'b1;
        #1 chk("R5 async clear over load", 32'(count), 32'h0);
        @(negedge clk); #1;
        rst = 1'b0;
        phase = "R5 release under load";
        wait_cycles(2);
        chk("R4 reload after clear", 32'(count), 32'hFF);
        load = 1'b0;
        phase = "R1 wrap from ones";
        wait_cycles(3);
        dir = 1'b0;
        phase = "R2 down after wrap";
        wait_cycles(20);

        run_cmp = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule